// File: doc/BRIEF.md
# Sample-Paced Interval Timer Bank

This block holds three independent 8-bit interval timers for an audio sound generator. They do not run from the system clock. Each one advances on a one-cycle sample strobe that arrives at the audio rate, 44.1 kHz. The time between two strobes is about 22.68 µs.

Each timer has a 3-bit prescale setting n. With setting n, the timer advances once every 2^n strobes, so the increment period runs from one sample up to 128 samples (about 2.9 ms). Software writes a start value into a timer's count register, and the timer counts upward from there. When the count steps into all ones (FFH), the timer sets a sticky pending flag, but only if that timer's interrupt is enabled. The wait is therefore (255 − start value) × 2^n sample periods. Loading FEH gives the shortest wait, which is one increment period.

Writes go through a simple write-only register port. Each timer has a one-cycle acknowledge input that clears its pending flag.

Top module: `sampleTimerBank`

## Requirements
- R1: The three timers run independently. The write address map is:
  - address 2·i loads the count of timer i;
  - address 2·i+1 sets the prescale of timer i from wrData[2:0];
  - address 6 sets the interrupt enable mask, with bit i enabling timer i.
- R2: With prescale n, a timer's count advances only on a sample strobe, and only on every 2^n-th strobe.
- R3: After timer i is loaded with value v and enabled, irqPending[i] becomes visible in the first cycle after the clock edge that samples strobe number (255 − v)·2^n. It does not become visible one strobe earlier.
- R4: A count write loads wrData into the counter and restarts that timer's prescale divider. If a strobe arrives in the same cycle as the write, the write wins and no increment happens. The first increment comes 2^n strobes after the write.
- R5: A pending flag is set only by an increment from FEH into FFH. Loading FFH directly does not set it.
- R6: A timer whose enable bit is 0 never sets its pending flag.
- R7: A pulse on ackIn[i] clears irqPending[i].
- R8: If an increment into FFH and ackIn[i] fall in the same cycle, the flag ends up set.
- R9: From FFH the counter wraps to 00H and keeps counting. The next pending event comes 256 increments after the previous one.
- R10: A prescale write takes effect from the next strobe and leaves the count value unchanged.
- R11: After reset, all counters, dividers, prescale settings, enables and pending flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleTick | input | 1 | One-cycle audio sample strobe |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | 3 | Register write address |
| wrData | input | 8 | Register write data |
| ackIn | input | 3 | Per-timer pending acknowledge pulse |
| irqPending | output | 3 | Per-timer sticky interrupt pending flags |

## Verification
Two pairs of events can fall in the same cycle:
- **Acknowledge and a new FFH event.** The bench raises ackIn together with the strobe that moves a timer from FEH into FFH. The flag must stay set, and only a later lone acknowledge may clear it.
- **Count write and a sample strobe.** The bench loads FEH while sampleTick is high. The bench judges the result from the flag: it must still be clear after that cycle, and it must rise on exactly the next strobe.

// File: rtl/sampleTimerPkg.sv
package sampleTimerPkg;
  localparam int NUM_TIMERS = 3;
  localparam int CNT_W      = 8;
  localparam int PRE_W      = 3;
  localparam int ADDR_W     = 3;
  // Widest divider count is 2^(2^PRE_W - 1) - 1, which needs 2^PRE_W - 1 bits.
  localparam int DIV_W      = (1 << PRE_W) - 1;
  localparam int EN_ADDR    = 2 * NUM_TIMERS;

  // Per-timer control strobes passed from the control block to the datapath.
  typedef struct packed {
    logic [NUM_TIMERS-1:0] load;
    logic [NUM_TIMERS-1:0] inc;
    logic [NUM_TIMERS-1:0] allow;
    logic [NUM_TIMERS-1:0] ack;
  } timerStrobes_t;
endpackage

// File: rtl/timerBankCtrl.sv
module timerBankCtrl
  import sampleTimerPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sampleTick,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [CNT_W-1:0]      wrData,
  input  logic [NUM_TIMERS-1:0] ackIn,
  output timerStrobes_t         strobes
);
  logic [NUM_TIMERS-1:0] enMask;
  logic [NUM_TIMERS-1:0] loadVec;
  logic [NUM_TIMERS-1:0] incVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enMask <= '0;
    end else if (wrEn && wrAddr == ADDR_W'(EN_ADDR)) begin
      enMask <= wrData[NUM_TIMERS-1:0];
    end
  end

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_div
    logic [PRE_W-1:0] prescale;
    logic [DIV_W-1:0] divCnt;
    logic [DIV_W:0]   divLimit;
    logic             loadHit;
    logic             ctlHit;
    logic             divDone;

    assign loadHit  = wrEn && (wrAddr == ADDR_W'(2 * i));
    assign ctlHit   = wrEn && (wrAddr == ADDR_W'(2 * i + 1));
    assign divLimit = ((DIV_W + 1)'(1) << prescale) - (DIV_W + 1)'(1);
    // >= keeps a shortened period safe when the divider is already past the new limit.
    assign divDone  = {1'b0, divCnt} >= divLimit;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        prescale <= '0;
      end else if (ctlHit) begin
        prescale <= wrData[PRE_W-1:0];
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN || loadHit) begin
        divCnt <= '0;
      end else if (sampleTick) begin
        divCnt <= divDone ? '0 : divCnt + DIV_W'(1);
      end
    end

    assign loadVec[i] = loadHit;
    assign incVec[i]  = sampleTick && divDone && !loadHit;
  end

  assign strobes.load  = loadVec;
  assign strobes.inc   = incVec;
  assign strobes.allow = enMask;
  assign strobes.ack   = ackIn;
endmodule

// File: rtl/timerBankData.sv
module timerBankData
  import sampleTimerPkg::*;
(
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic [CNT_W-1:0]                     wrData,
  input  timerStrobes_t                        strobes,
  output logic [NUM_TIMERS-1:0][CNT_W-1:0]     counts,
  output logic [NUM_TIMERS-1:0]                pending
);
  localparam logic [CNT_W-1:0] ALL_ONES  = '1;
  localparam logic [CNT_W-1:0] NEAR_FULL = ALL_ONES - CNT_W'(1);

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
    logic [CNT_W-1:0] countQ;
    logic             pendQ;
    logic             hitFull;

    assign hitFull = strobes.inc[i] && (countQ == NEAR_FULL) && strobes.allow[i];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        countQ <= '0;
      end else if (strobes.load[i]) begin
        countQ <= wrData;
      end else if (strobes.inc[i]) begin
        countQ <= countQ + CNT_W'(1);
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pendQ <= 1'b0;
      end else if (hitFull) begin
        pendQ <= 1'b1;
      end else if (strobes.ack[i]) begin
        pendQ <= 1'b0;
      end
    end

    assign counts[i]  = countQ;
    assign pending[i] = pendQ;
  end
endmodule

// File: rtl/sampleTimerBank.sv
module sampleTimerBank
  import sampleTimerPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sampleTick,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [CNT_W-1:0]      wrData,
  input  logic [NUM_TIMERS-1:0] ackIn,
  output logic [NUM_TIMERS-1:0] irqPending
);
  timerStrobes_t                    strobes;
  logic [NUM_TIMERS-1:0][CNT_W-1:0] counts;

  timerBankCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleTick (sampleTick),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .ackIn      (ackIn),
    .strobes    (strobes)
  );

  timerBankData u_data (
    .clk     (clk),
    .rstN    (rstN),
    .wrData  (wrData),
    .strobes (strobes),
    .counts  (counts),
    .pending (irqPending)
  );
endmodule

// File: rtl/sampleTimerBankChk.sv
module sampleTimerBankChk
  import sampleTimerPkg::*;
(
  input logic                             clk,
  input logic                             rstN,
  input logic                             sampleTick,
  input logic [CNT_W-1:0]                 wrData,
  input logic [NUM_TIMERS-1:0]            ackIn,
  input logic [NUM_TIMERS-1:0]            irqPending,
  input timerStrobes_t                    strobes,
  input logic [NUM_TIMERS-1:0][CNT_W-1:0] counts
);
  localparam logic [CNT_W-1:0] ALL_ONES  = '1;
  localparam logic [CNT_W-1:0] NEAR_FULL = ALL_ONES - CNT_W'(1);

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_chk
    assert_inc_on_tick_R2: assert property (@(posedge clk) disable iff (!rstN)
      strobes.inc[i] |-> sampleTick);

    assert_load_value_R4: assert property (@(posedge clk) disable iff (!rstN)
      strobes.load[i] |=> counts[i] == $past(wrData));

    assert_rise_on_full_R5: assert property (@(posedge clk) disable iff (!rstN)
      $rose(irqPending[i]) |-> (counts[i] == ALL_ONES && $past(counts[i]) == NEAR_FULL));

    assert_rise_needs_enable_R6: assert property (@(posedge clk) disable iff (!rstN)
      $rose(irqPending[i]) |-> $past(strobes.allow[i]));

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
      (ackIn[i] && !strobes.inc[i]) |=> !irqPending[i]);

    assert_set_beats_ack_R8: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.inc[i] && counts[i] == NEAR_FULL && strobes.allow[i]) |=> irqPending[i]);

    assert_wrap_to_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.inc[i] && counts[i] == ALL_ONES) |=> counts[i] == '0);
  end
endmodule

bind sampleTimerBank sampleTimerBankChk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sampleTick (sampleTick),
  .wrData     (wrData),
  .ackIn      (ackIn),
  .irqPending (irqPending),
  .strobes    (strobes),
  .counts     (counts)
);

// File: tb/sampleTimerBank_bench.sv
module sampleTimerBank_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleTick = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [2:0] ackIn = '0;
  logic [2:0] irqPending;

  int total = 0;
  int failed = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sampleTimerBank u_sampleTimerBank (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .ackIn(ackIn), .irqPending(irqPending)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [2:0] a, input logic [7:0] d, input bit withTick = 0);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d; sampleTick = withTick;
    @(negedge clk);
    wrEn = 1'b0; sampleTick = 1'b0;
  endtask

  task automatic doTick(input logic [2:0] ackMask = 3'b000);
    @(negedge clk);
    sampleTick = 1'b1; ackIn = ackMask;
    @(negedge clk);
    sampleTick = 1'b0; ackIn = '0;
  endtask

  task automatic doAck(input logic [2:0] m);
    @(negedge clk);
    ackIn = m;
    @(negedge clk);
    ackIn = '0;
  endtask

  // Number of strobes until irqPending[t] is first seen high, or -1.
  task automatic measure(input int t, input int maxT, output int got);
    got = -1;
    for (int k = 1; k <= maxT; k++) begin
      doTick();
      if (irqPending[t]) begin
        got = k;
        break;
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    int got;
    int expd;
    int rA, rB, rC;
    logic [7:0] loads [3] = '{8'hFE, 8'hFC, 8'hF8};

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11: reset state, nothing pending
    check(irqPending == 3'b000, "R11 reset pending", int'(irqPending), 0);
    // R11: enables reset to zero, so a FEH load and one strobe set nothing
    doWrite(3'd0, 8'hFE);
    doTick();
    check(irqPending == 3'b000, "R11 enables cleared by reset", int'(irqPending), 0);

    doWrite(3'd6, 8'h07);

    // R2 R3: sweep every timer, every prescale, several start values
    for (int t = 0; t < 3; t++) begin
      for (int n = 0; n < 8; n++) begin
        for (int j = 0; j < 3; j++) begin
          doWrite(3'(2 * t + 1), 8'(n));
          doWrite(3'(2 * t), loads[j]);
          doAck(3'(1 << t));
          expd = (255 - int'(loads[j])) << n;
          measure(t, expd + 4, got);
          check(got == expd, "R2/R3 strobes to pending", got, expd);
        end
      end
    end

    // R1: three timers running at once with different settings
    doWrite(3'd1, 8'd0); doWrite(3'd0, 8'hF0);
    doWrite(3'd3, 8'd1); doWrite(3'd2, 8'hF8);
    doWrite(3'd5, 8'd2); doWrite(3'd4, 8'hFC);
    doAck(3'b111);
    rA = -1; rB = -1; rC = -1;
    for (int k = 1; k <= 20; k++) begin
      doTick();
      if (irqPending[0] && rA < 0) rA = k;
      if (irqPending[1] && rB < 0) rB = k;
      if (irqPending[2] && rC < 0) rC = k;
    end
    check(rA == 15, "R1 timer A independent", rA, 15);
    check(rB == 14, "R1 timer B independent", rB, 14);
    check(rC == 12, "R1 timer C independent", rC, 12);

    // R4: reload restarts the divider (prescale 2)
    doWrite(3'd1, 8'd2);
    doWrite(3'd0, 8'hF0);
    doAck(3'b001);
    doTick(); doTick();
    doWrite(3'd0, 8'hFE);
    measure(0, 8, got);
    check(got == 4, "R4 reload restarts divider", got, 4);

    // R4: write and strobe in the same cycle, the write wins
    doWrite(3'd1, 8'd0);
    doAck(3'b001);
    doWrite(3'd0, 8'hFE, 1);
    check(irqPending[0] == 1'b0, "R4 load beats same-cycle strobe", int'(irqPending[0]), 0);
    doTick();
    check(irqPending[0] == 1'b1, "R4 first increment after load", int'(irqPending[0]), 1);

    // R8: acknowledge together with a new FFH event keeps the flag
    doWrite(3'd0, 8'hFE);
    doTick(3'b001);
    check(irqPending[0] == 1'b1, "R8 set beats ack", int'(irqPending[0]), 1);
    // R7: acknowledge alone clears
    doAck(3'b001);
    check(irqPending[0] == 1'b0, "R7 ack clears", int'(irqPending[0]), 0);

    // R5: loading FFH does not set pending; wrap then 255 more to FFH
    doWrite(3'd0, 8'hFF);
    repeat (3) @(negedge clk);
    check(irqPending[0] == 1'b0, "R5 load FFH no pending", int'(irqPending[0]), 0);
    doTick();
    check(irqPending[0] == 1'b0, "R5 step FFH->00H no pending", int'(irqPending[0]), 0);
    measure(0, 260, got);
    check(got == 255, "R5 pending after 00H->FFH", got, 255);

    // R9: wrap, next event 256 increments later
    doWrite(3'd0, 8'hFE);
    doAck(3'b001);
    doTick();
    check(irqPending[0] == 1'b1, "R9 first event", int'(irqPending[0]), 1);
    doAck(3'b001);
    measure(0, 300, got);
    check(got == 256, "R9 wrap period", got, 256);

    // R10: prescale change mid-count keeps the count
    doWrite(3'd3, 8'd0);
    doWrite(3'd2, 8'hF0);
    doAck(3'b010);
    repeat (5) doTick();
    doWrite(3'd3, 8'd1);
    measure(1, 30, got);
    check(got == 20, "R10 prescale change", got, 20);

    // R6: disabled timer never pends
    doWrite(3'd6, 8'h06);
    doWrite(3'd1, 8'd0);
    doWrite(3'd0, 8'hFE);
    doAck(3'b111);
    repeat (300) doTick();
    check(irqPending[0] == 1'b0, "R6 disabled no pending", int'(irqPending[0]), 0);

    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule